// File: doc/BRIEF.md
# Bus-Interface Quad Register

A four-bit storage register that sits between a local data source and a shared bus. The value on the data input is captured on a rising clock edge only when two active-low load gates are both asserted; at any other edge the register keeps what it has. An active-high clear empties the register at once, without waiting for the clock. The stored word reaches the bus through tri-state drivers that are gated by two active-low output controls; raising either control floats the whole bus port.

The drivers let go of the bus faster than they take it. A small driver state machine with three named states controls this. `DRV_OFF` means released. `DRV_ARM` means both controls have been seen low at a rising edge and the guard count is running. `DRV_ON` means driving. Its transitions are: arm (`DRV_OFF`→`DRV_ARM`, both controls low at an edge), abort (`DRV_ARM`→`DRV_OFF`, a control high at an edge), grant (`DRV_ARM`→`DRV_ON`, guard count reached), and drop (`DRV_ON`→`DRV_OFF`, a control high at an edge). The drive signal is also qualified combinationally by the current controls, so a release request cuts the drivers in the same cycle. A take request waits for consecutive edges. This gives break-before-make hand-over when two such registers share one bus.

Top module: `busreg_quad`

## Requirements
- R1: At a rising `clk` edge with `clr` low and both `ld_a_n` and `ld_b_n` low, `q_o` takes the value of `d_i`.
- R2: At a rising `clk` edge with `clr` low and either `ld_a_n` or `ld_b_n` high, `q_o` keeps its previous value.
- R3: While `clr` is high, `q_o` is 4'b0000 immediately and at every clock edge, even when a load is requested.
- R4: While `drive_o` is 1, `bus_io` carries the stored value `q_o`.
- R5: In any cycle where `oe_a_n` or `oe_b_n` is high, `drive_o` is 0 and `bus_io` is released, in that same cycle.
- R6: Output gating never changes storage: a value loaded while the drivers are released appears on `bus_io` once they are enabled again.
- R7: `drive_o` becomes 1 only after GUARD_CYCLES+1 consecutive rising edges at which both output controls were sampled low (2 edges by default), and it stays 1 while both stay low.
- R8: While `rst_n` is low the driver machine is in `DRV_OFF` and `drive_o` is 0.
- R9: When control of a shared bus moves from one register to another by raising one's controls and lowering the other's in the same cycle, both `drive_o` outputs are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the driver state machine |
| clr | input | 1 | Active-high asynchronous clear of the stored word |
| ld_a_n | input | 1 | First active-low load gate |
| ld_b_n | input | 1 | Second active-low load gate |
| d_i | input | WIDTH | Data to be captured |
| oe_a_n | input | 1 | First active-low output control |
| oe_b_n | input | 1 | Second active-low output control |
| bus_io | output | WIDTH | Tri-state bus drive; high impedance when released |
| q_o | output | WIDTH | Stored word, always visible for checking |
| drive_o | output | 1 | 1 while the bus drivers are enabled |

## Verification
The assertions check, on every edge, these rules: load capture, hold under a closed gate, clear forcing zero, a release request ending `DRV_ON` at the next edge, and that `drive_o` never rises without both controls having been low at the previous edge. The bench's scenarios show the end-to-end behaviour that no single-cycle property covers. These are the exact guard edge at which driving starts, the same-cycle release, a value loaded while floating showing up after re-enable, and two registers on one shared bus handing over without overlap under random control swaps.

// File: rtl/busreg_pkg.sv
package busreg_pkg;

    typedef enum logic [1:0] {
        DRV_OFF = 2'd0,
        DRV_ARM = 2'd1,
        DRV_ON  = 2'd2
    } drv_state_e;

    // Both active-low gates must be asserted.
    function automatic logic both_low(input logic a_n, input logic b_n);
        return ~(a_n | b_n);
    endfunction

endpackage

// File: rtl/busreg_ctl.sv
module busreg_ctl (
    input  logic ld_a_n,
    input  logic ld_b_n,
    input  logic oe_a_n,
    input  logic oe_b_n,
    output logic load_req,
    output logic out_req
);
    import busreg_pkg::*;

    always_comb begin
        load_req = both_low(ld_a_n, ld_b_n);
        out_req  = both_low(oe_a_n, oe_b_n);
    end

endmodule

// File: rtl/busreg_store.sv
module busreg_store #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             load_req,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            always_ff @(posedge clk or posedge clr) begin
                if (clr)
                    q_o[i] <= 1'b0;
                else if (load_req)
                    q_o[i] <= d_i[i];
            end
        end
    endgenerate

    // R1: an open gate captures the data word
    p_load_r1: assert property (@(posedge clk) disable iff (clr)
        load_req |=> (clr || q_o == $past(d_i)));

    // R2: a closed gate keeps the stored word
    p_hold_r2: assert property (@(posedge clk) disable iff (clr)
        !load_req |=> (clr || q_o == $past(q_o)));

    // R3: clear wins over any load
    p_clear_r3: assert property (@(posedge clk) disable iff (!clr)
        q_o == '0);

endmodule

// File: rtl/busreg_drive_fsm.sv
module busreg_drive_fsm #(
    parameter int GUARD_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic out_req,
    output logic drive
);
    import busreg_pkg::*;

    localparam int CW = (GUARD_CYCLES < 2) ? 1 : $clog2(GUARD_CYCLES + 1);
    localparam logic [CW-1:0] GUARD_LAST = CW'(GUARD_CYCLES);

    drv_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DRV_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            DRV_OFF: begin
                if (out_req) begin
                    state_d = DRV_ARM;
                    cnt_d   = CW'(1);
                end
            end
            DRV_ARM: begin
                if (!out_req) begin
                    state_d = DRV_OFF;
                    cnt_d   = '0;
                end else if (cnt_q >= GUARD_LAST) begin
                    state_d = DRV_ON;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            DRV_ON: begin
                if (!out_req) begin
                    state_d = DRV_OFF;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = DRV_OFF;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs: release is immediate, take waits for DRV_ON
    always_comb begin
        unique case (state_q)
            DRV_ON:  drive = out_req;
            default: drive = 1'b0;
        endcase
    end

    // R5: a release request ends driving at the next edge
    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !out_req |=> state_q != DRV_ON);

    // R7: driving never starts without a prior sampled request
    p_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive) |-> $past(out_req));

    // R7: DRV_ON is only reached from a requested edge
    p_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DRV_ON) |-> $past(out_req));

endmodule

// File: rtl/busreg_quad.sv
module busreg_quad #(
    parameter int WIDTH        = 4,
    parameter int GUARD_CYCLES = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ld_a_n,
    input  logic             ld_b_n,
    input  logic [WIDTH-1:0] d_i,
    input  logic             oe_a_n,
    input  logic             oe_b_n,
    output wire  [WIDTH-1:0] bus_io,
    output logic [WIDTH-1:0] q_o,
    output logic             drive_o
);

    logic load_req;
    logic out_req;
    logic [WIDTH-1:0] stored;
    logic drive;

    busreg_ctl u_ctl (
        .ld_a_n   (ld_a_n),
        .ld_b_n   (ld_b_n),
        .oe_a_n   (oe_a_n),
        .oe_b_n   (oe_b_n),
        .load_req (load_req),
        .out_req  (out_req)
    );

    busreg_store #(.WIDTH(WIDTH)) u_store (
        .clk      (clk),
        .clr      (clr),
        .load_req (load_req),
        .d_i      (d_i),
        .q_o      (stored)
    );

    busreg_drive_fsm #(.GUARD_CYCLES(GUARD_CYCLES)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .out_req (out_req),
        .drive   (drive)
    );

    assign q_o     = stored;
    assign drive_o = drive;
    assign bus_io  = drive ? stored : {WIDTH{1'bz}};

    // R8: no driving while in reset
    p_reset_off_r8: assert property (@(posedge clk) !rst_n |-> !drive_o);

endmodule

// File: tb/busreg_quad_tb.sv
module busreg_quad_tb;

    localparam int W = 4;
    localparam int GUARD = 1;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n;
    logic clr_a, la_a, lb_a, oa_a, ob_a;
    logic clr_b, la_b, lb_b, oa_b, ob_b;
    logic [W-1:0] d_a, d_b;
    wire  [W-1:0] bus;
    logic [W-1:0] q_a, q_b;
    logic drv_a, drv_b;

    busreg_quad #(.WIDTH(W), .GUARD_CYCLES(GUARD)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr_a), .ld_a_n(la_a), .ld_b_n(lb_a),
        .d_i(d_a), .oe_a_n(oa_a), .oe_b_n(ob_a), .bus_io(bus), .q_o(q_a),
        .drive_o(drv_a)
    );

    busreg_quad #(.WIDTH(W), .GUARD_CYCLES(GUARD)) u_peer (
        .clk(clk), .rst_n(rst_n), .clr(clr_b), .ld_a_n(la_b), .ld_b_n(lb_b),
        .d_i(d_b), .oe_a_n(oa_b), .oe_b_n(ob_b), .bus_io(bus), .q_o(q_b),
        .drive_o(drv_b)
    );

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    // bench model
    logic [W-1:0] mq_a, mq_b;
    int mcnt_a, mcnt_b;

    function automatic bit exp_drive(int cnt, logic o1, logic o2);
        return (cnt >= GUARD + 1) && !o1 && !o2;
    endfunction

    function automatic logic [W-1:0] next_q(logic [W-1:0] q, logic c,
                                            logic l1, logic l2, logic [W-1:0] d);
        if (c) return '0;
        if (!l1 && !l2) return d;
        return q;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // inputs set just after a falling edge; check, then advance one clock
    task automatic step();
        bit ea, eb;
        if (clr_a) mq_a = '0;
        if (clr_b) mq_b = '0;
        #2;
        ea = rst_n && exp_drive(mcnt_a, oa_a, ob_a);
        eb = rst_n && exp_drive(mcnt_b, oa_b, ob_b);
        chk(q_a == mq_a, "R1 R2 R3 stored A", q_a, mq_a);
        chk(q_b == mq_b, "R1 R2 R3 stored B", q_b, mq_b);
        chk(drv_a == ea, "R5 R7 R8 drive A", drv_a, ea);
        chk(drv_b == eb, "R5 R7 R8 drive B", drv_b, eb);
        chk(!(drv_a && drv_b), "R9 overlap", {drv_a, drv_b}, 0);
        if (drv_a && !drv_b) chk(bus == q_a, "R4 bus A", bus, q_a);
        if (drv_b && !drv_a) chk(bus == q_b, "R4 bus B", bus, q_b);
        @(posedge clk);
        mq_a = next_q(mq_a, clr_a, la_a, lb_a, d_a);
        mq_b = next_q(mq_b, clr_b, la_b, lb_b, d_b);
        mcnt_a = (!rst_n || oa_a || ob_a) ? 0 : mcnt_a + 1;
        mcnt_b = (!rst_n || oa_b || ob_b) ? 0 : mcnt_b + 1;
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        rst_n = 1'b0;
        clr_a = 1'b1; la_a = 1'b1; lb_a = 1'b1; oa_a = 1'b1; ob_a = 1'b1; d_a = '0;
        clr_b = 1'b1; la_b = 1'b1; lb_b = 1'b1; oa_b = 1'b1; ob_b = 1'b1; d_b = '0;
        mq_a = '0; mq_b = '0; mcnt_a = 0; mcnt_b = 0;
        @(negedge clk);
        // R8: requested output during reset stays released
        oa_a = 1'b0; ob_a = 1'b0;
        step(); step(); step();
        chk(drv_a == 1'b0, "R8 reset drive", drv_a, 0);
        oa_a = 1'b1; ob_a = 1'b1;
        rst_n = 1'b1; clr_a = 1'b0; clr_b = 1'b0;
        step();
        chk(q_a == 4'h0, "R3 reset value", q_a, 0);

        // R1: load with both gates low
        la_a = 1'b0; lb_a = 1'b0; d_a = 4'hA;
        step();
        chk(q_a == 4'hA, "R1 load A", q_a, 4'hA);

        // R2: either gate high holds
        la_a = 1'b1; d_a = 4'h5;
        step();
        chk(q_a == 4'hA, "R2 hold gate a", q_a, 4'hA);
        la_a = 1'b0; lb_a = 1'b1; d_a = 4'h3;
        step();
        chk(q_a == 4'hA, "R2 hold gate b", q_a, 4'hA);

        // R3: clear beats a requested load
        lb_a = 1'b0; d_a = 4'hF; clr_a = 1'b1;
        #2;
        chk(q_a == 4'h0, "R3 clear immediate", q_a, 0);
        step();
        chk(q_a == 4'h0, "R3 clear over load", q_a, 0);
        clr_a = 1'b0; d_a = 4'hC;
        step();
        la_a = 1'b1; lb_a = 1'b1;

        // R7: guard on enable
        oa_a = 1'b0; ob_a = 1'b0;
        #2;
        chk(drv_a == 1'b0, "R7 no drive edge 0", drv_a, 0);
        step();
        chk(drv_a == 1'b0, "R7 no drive edge 1", drv_a, 0);
        step();
        chk(drv_a == 1'b1, "R7 drive after edge 2", drv_a, 1);
        chk(bus == 4'hC, "R4 bus value", bus, 4'hC);

        // R5: same-cycle release
        ob_a = 1'b1;
        #2;
        chk(drv_a == 1'b0, "R5 release same cycle", drv_a, 0);

        // R6: load while floating, then re-enable
        la_a = 1'b0; lb_a = 1'b0; d_a = 4'h6;
        step();
        la_a = 1'b1; lb_a = 1'b1;
        chk(q_a == 4'h6, "R6 load while floating", q_a, 4'h6);
        ob_a = 1'b0;
        step(); step();
        chk(drv_a == 1'b1 && bus == 4'h6, "R6 value after re-enable", bus, 4'h6);

        // R9: hand-over A -> B
        clr_b = 1'b0; la_b = 1'b0; lb_b = 1'b0; d_b = 4'h9;
        step();
        la_b = 1'b1; lb_b = 1'b1;
        oa_a = 1'b1; oa_b = 1'b0; ob_b = 1'b0;
        #2;
        chk(!drv_a && !drv_b, "R9 gap after swap", {drv_a, drv_b}, 0);
        step(); step();
        chk(drv_b == 1'b1 && bus == 4'h9, "R9 B owns bus", bus, 4'h9);

        // random mix with control swaps
        for (int i = 0; i < 400; i++) begin
            bool_rand();
            step();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    task automatic bool_rand();
        int sel;
        clr_a = ($urandom % 16) == 0;
        clr_b = ($urandom % 16) == 0;
        la_a = $urandom % 2; lb_a = ($urandom % 3) == 0;
        la_b = $urandom % 2; lb_b = ($urandom % 3) == 0;
        d_a = W'($urandom); d_b = W'($urandom);
        if (($urandom % 6) == 0) begin
            sel = $urandom % 3;
            // swap ownership or release both; never request both at once
            oa_a = (sel != 0); ob_a = 1'b0;
            oa_b = (sel != 1); ob_b = 1'b0;
        end else if (($urandom % 8) == 0) begin
            ob_a = 1'b1;
        end
    endtask

endmodule